// File: doc/BRIEF.md
# Register File with Deferred-Fault Poison Bits

This block is a general-purpose register file in which every register carries one extra poison bit. A speculative load that hits a fault does not raise an exception; it marks its destination as poisoned instead. Any later write that consumes a poisoned source passes the poison on to its own destination. Software therefore needs only one speculation check, placed on the last register of a dependent chain, to learn whether anything earlier in that chain faulted.

The block has two operand read ports, one write port and one check port. The write port carries three operation flags: arithmetic, normal load and speculative load. It also carries a fault indication and two flags that say which operand read ports the operation consumes. The poison bits of the consumed operands come from the stored state at the start of the cycle. The check port answers in the same cycle with the register's poison state and a request to branch to fix-up code.

Top module: `poison_regfile`

## Requirements
- R1: Reset clears the data word and the poison bit of every register.
- R2: Register 0 always reads as zero with a clear poison bit on every read and check port, and any write addressed to it is ignored.
- R3: A speculative load (`wrSpecLoad`=1) with `wrLoadFault`=1 writes `wrData` and sets the destination's poison bit. It raises no other indication.
- R4: A speculative load with `wrLoadFault`=0 and no poisoned consumed source writes `wrData` and clears the destination's poison bit, even if that register was poisoned before.
- R5: If any operand port flagged by `wrSrcUseA`/`wrSrcUseB` addresses a register that was poisoned at the start of the cycle, the destination's poison bit is set. This holds for arithmetic, normal-load and speculative-load writes.
- R6: An arithmetic or normal-load write whose flagged sources are all clean writes `wrData` and clears the destination's poison bit. Operand ports that are not flagged do not contribute.
- R7: `chkPoisoned` reports the poison bit of `chkAddr` at all times. `chkFixup` is 1 exactly when `chkEn`=1 and that bit is set.
- R8: The check outputs are combinational. They reflect a write to `chkAddr` in the same cycle.
- R9: A read port whose address equals the address of a write in the same cycle returns the new data and the new poison bit.
- R10: After a faulting speculative load and a chain of dependent writes, one check on the last register of the chain requests fix-up.
- R11: Flag priority is speculative load over normal load over arithmetic. `wrLoadFault` has no effect unless `wrSpecLoad`=1.
- R12: When none of the three operation flags is set, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | AW | Operand port A register index |
| rdDataA | output | DATA_W | Operand port A data |
| rdNatA | output | 1 | Operand port A poison bit |
| rdAddrB | input | AW | Operand port B register index |
| rdDataB | output | DATA_W | Operand port B data |
| rdNatB | output | 1 | Operand port B poison bit |
| wrAddr | input | AW | Destination register index |
| wrData | input | DATA_W | Result data to write |
| wrAluOp | input | 1 | Arithmetic result write |
| wrLoad | input | 1 | Normal load write |
| wrSpecLoad | input | 1 | Speculative load write |
| wrLoadFault | input | 1 | Speculative load met a fault |
| wrSrcUseA | input | 1 | Write consumes operand port A |
| wrSrcUseB | input | 1 | Write consumes operand port B |
| chkEn | input | 1 | Speculation check valid |
| chkAddr | input | AW | Register under check |
| chkPoisoned | output | 1 | Poison bit of the checked register |
| chkFixup | output | 1 | Branch-to-fix-up request |

## Verification
The bench builds the block with 16 registers of 32 bits. With that size the highest index, register 15, and register 0 both sit at the edges of a short directed run. The small width keeps the data patterns readable while the poison logic is the same as at full size. Same-cycle cases are driven with read, check and write addresses aligned, so bypass and propagation are tested apart from each other.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ALU  = 2'd1,
    OP_LOAD = 2'd2,
    OP_SPEC = 2'd3
  } wrKind_t;

  typedef struct packed {
    logic we;
    logic nat;
  } wrStrobe_t;

endpackage

// File: rtl/poison_ctrl.sv
module poison_ctrl #(
  parameter int AW = 7
) (
  input  logic                  wrAluOp,
  input  logic                  wrLoad,
  input  logic                  wrSpecLoad,
  input  logic                  wrLoadFault,
  input  logic                  wrSrcUseA,
  input  logic                  wrSrcUseB,
  input  logic [AW-1:0]         wrAddr,
  input  logic                  srcNatA,
  input  logic                  srcNatB,
  output poison_pkg::wrStrobe_t strobe
);
  import poison_pkg::*;

  wrKind_t kind;
  logic    srcNat;
  logic    faultNat;

  always_comb begin
    if (wrSpecLoad)   kind = OP_SPEC;
    else if (wrLoad)  kind = OP_LOAD;
    else if (wrAluOp) kind = OP_ALU;
    else              kind = OP_NONE;
  end

  always_comb begin
    srcNat   = (wrSrcUseA & srcNatA) | (wrSrcUseB & srcNatB);
    faultNat = (kind == OP_SPEC) & wrLoadFault;
    strobe.we  = (kind != OP_NONE) && (wrAddr != '0);
    strobe.nat = srcNat | faultNat;
  end

endmodule

// File: rtl/poison_dp.sv
module poison_dp #(
  parameter int NREGS  = 128,
  parameter int DATA_W = 64,
  parameter int NPORTS = 3,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  poison_pkg::wrStrobe_t strobe,
  input  logic [AW-1:0]         wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [AW-1:0]         rdAddr  [NPORTS],
  output logic [DATA_W-1:0]     rdData  [NPORTS],
  output logic                  rdNat   [NPORTS],
  output logic                  rawNat  [NPORTS]
);

  logic [DATA_W-1:0] regData [NREGS];
  logic              regNat  [NREGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) begin
        regData[i] <= '0;
        regNat[i]  <= 1'b0;
      end
    end else if (strobe.we) begin
      regData[wrAddr] <= wrData;
      regNat[wrAddr]  <= strobe.nat;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic isZero;
    logic hit;
    assign isZero = (rdAddr[p] == '0);
    assign hit    = strobe.we && (rdAddr[p] == wrAddr);

    always_comb begin
      rawNat[p] = isZero ? 1'b0 : regNat[rdAddr[p]];
      if (isZero) begin
        rdData[p] = '0;
        rdNat[p]  = 1'b0;
      end else if (hit) begin
        rdData[p] = wrData;
        rdNat[p]  = strobe.nat;
      end else begin
        rdData[p] = regData[rdAddr[p]];
        rdNat[p]  = regNat[rdAddr[p]];
      end
    end
  end

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile #(
  parameter int NREGS  = 128,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdNatA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdNatB,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrAluOp,
  input  logic              wrLoad,
  input  logic              wrSpecLoad,
  input  logic              wrLoadFault,
  input  logic              wrSrcUseA,
  input  logic              wrSrcUseB,
  input  logic              chkEn,
  input  logic [AW-1:0]     chkAddr,
  output logic              chkPoisoned,
  output logic              chkFixup
);
  localparam int NPORTS = 3;

  poison_pkg::wrStrobe_t strobe;
  logic [AW-1:0]     portAddr [NPORTS];
  logic [DATA_W-1:0] portData [NPORTS];
  logic              portNat  [NPORTS];
  logic              portRaw  [NPORTS];

  assign portAddr[0] = rdAddrA;
  assign portAddr[1] = rdAddrB;
  assign portAddr[2] = chkAddr;

  poison_ctrl #(.AW(AW)) u_ctrl (
    .wrAluOp     (wrAluOp),
    .wrLoad      (wrLoad),
    .wrSpecLoad  (wrSpecLoad),
    .wrLoadFault (wrLoadFault),
    .wrSrcUseA   (wrSrcUseA),
    .wrSrcUseB   (wrSrcUseB),
    .wrAddr      (wrAddr),
    .srcNatA     (portRaw[0]),
    .srcNatB     (portRaw[1]),
    .strobe      (strobe)
  );

  poison_dp #(.NREGS(NREGS), .DATA_W(DATA_W), .NPORTS(NPORTS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (portAddr),
    .rdData (portData),
    .rdNat  (portNat),
    .rawNat (portRaw)
  );

  assign rdDataA     = portData[0];
  assign rdNatA      = portNat[0];
  assign rdDataB     = portData[1];
  assign rdNatB      = portNat[1];
  assign chkPoisoned = portNat[2];
  assign chkFixup    = chkEn & portNat[2];

endmodule

// File: rtl/poison_regfile_chk.sv
module poison_regfile_chk #(
  parameter int NREGS  = 128,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [AW-1:0]     rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdNatA,
  input logic [AW-1:0]     wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrAluOp,
  input logic              wrLoad,
  input logic              wrSpecLoad,
  input logic              wrLoadFault,
  input logic              wrSrcUseA,
  input logic              wrSrcUseB,
  input logic              chkEn,
  input logic [AW-1:0]     chkAddr,
  input logic              chkPoisoned,
  input logic              chkFixup
);

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0 && !rdNatA));

  // R7
  fixup_needs_poison_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkFixup |-> (chkEn && chkPoisoned));

  // R3
  spec_fault_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSpecLoad && wrLoadFault && wrAddr != '0)
    |=> ((chkAddr == $past(wrAddr) && !wrAluOp && !wrLoad && !wrSpecLoad) |-> chkPoisoned));

  // R8
  same_cycle_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSpecLoad && wrLoadFault && wrAddr != '0 && chkAddr == wrAddr && chkEn) |-> chkFixup);

  // R9
  bypass_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wrAluOp || wrLoad || wrSpecLoad) && wrAddr != '0 && rdAddrA == wrAddr) |-> (rdDataA == wrData));

  // R6
  clean_alu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAluOp && !wrLoad && !wrSpecLoad && !wrSrcUseA && !wrSrcUseB && wrAddr != '0 && rdAddrA == wrAddr)
    |-> !rdNatA);

endmodule

bind poison_regfile poison_regfile_chk #(.NREGS(NREGS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdAddrA     (rdAddrA),
  .rdDataA     (rdDataA),
  .rdNatA      (rdNatA),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .wrAluOp     (wrAluOp),
  .wrLoad      (wrLoad),
  .wrSpecLoad  (wrSpecLoad),
  .wrLoadFault (wrLoadFault),
  .wrSrcUseA   (wrSrcUseA),
  .wrSrcUseB   (wrSrcUseB),
  .chkEn       (chkEn),
  .chkAddr     (chkAddr),
  .chkPoisoned (chkPoisoned),
  .chkFixup    (chkFixup)
);

// File: tb/poison_regfile_tb.sv
module poison_regfile_tb;
  localparam int NREGS  = 16;
  localparam int DATA_W = 32;
  localparam int AW     = $clog2(NREGS);

  logic              clk = 1'b0;
  logic              rstN;
  logic [AW-1:0]     rdAddrA, rdAddrB, wrAddr, chkAddr;
  logic [DATA_W-1:0] rdDataA, rdDataB, wrData;
  logic              rdNatA, rdNatB;
  logic              wrAluOp, wrLoad, wrSpecLoad, wrLoadFault, wrSrcUseA, wrSrcUseB;
  logic              chkEn, chkPoisoned, chkFixup;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  poison_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) u_dut (.*);

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrAluOp = 0; wrLoad = 0; wrSpecLoad = 0; wrLoadFault = 0;
    wrSrcUseA = 0; wrSrcUseB = 0; chkEn = 0;
    wrAddr = '0; wrData = '0; rdAddrA = '0; rdAddrB = '0; chkAddr = '0;
  endtask

  // drive at negedge, let it commit at the next posedge, return at the following negedge
  task automatic commit();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int kind, input int addr, input logic [DATA_W-1:0] d,
                    input logic fault, input int srcA, input logic useA,
                    input int srcB, input logic useB);
    idle();
    wrAluOp = (kind == 1); wrLoad = (kind == 2); wrSpecLoad = (kind == 3);
    wrAddr = AW'(addr); wrData = d; wrLoadFault = fault;
    rdAddrA = AW'(srcA); wrSrcUseA = useA;
    rdAddrB = AW'(srcB); wrSrcUseB = useB;
    commit();
  endtask

  task automatic look(input int addr);
    idle();
    rdAddrA = AW'(addr); chkAddr = AW'(addr); chkEn = 1;
    #1;
  endtask

  task automatic t_reset();
    look(5);
    check("R1 data after reset", rdDataA, '0);
    check("R1 poison after reset", {31'd0, rdNatA}, 0);
    look(15);
    check("R1 fixup after reset", {31'd0, chkFixup}, 0);
  endtask

  task automatic t_zero();
    wr(3, 0, 32'hFF, 1, 0, 0, 0, 0);
    look(0);
    check("R2 r0 data", rdDataA, '0);
    check("R2 r0 poison", {31'd0, chkPoisoned}, 0);
  endtask

  task automatic t_specFault();
    wr(3, 3, 32'h11, 1, 0, 0, 0, 0);
    look(3);
    check("R3 data", rdDataA, 32'h11);
    check("R3 poison", {31'd0, rdNatA}, 1);
    check("R7 fixup on poisoned", {31'd0, chkFixup}, 1);
    chkEn = 0; #1;
    check("R7 no fixup without enable", {31'd0, chkFixup}, 0);
    check("R7 poisoned reported", {31'd0, chkPoisoned}, 1);
  endtask

  task automatic t_specOk();
    wr(3, 4, 32'h44, 0, 0, 0, 0, 0);
    look(4);
    check("R4 data", rdDataA, 32'h44);
    check("R4 clean", {31'd0, rdNatA}, 0);
    wr(3, 3, 32'h33, 0, 0, 0, 0, 0);
    look(3);
    check("R4 overwrite clears poison", {31'd0, chkFixup}, 0);
  endtask

  task automatic t_propagate();
    wr(3, 3, 32'h1, 1, 0, 0, 0, 0);
    wr(1, 6, 32'h66, 0, 3, 1, 4, 1);
    look(6);
    check("R5 alu propagates", {31'd0, rdNatA}, 1);
    wr(2, 12, 32'hC, 0, 4, 0, 3, 1);
    look(12);
    check("R5 load propagates from B", {31'd0, rdNatA}, 1);
    wr(1, 6, 32'h67, 0, 3, 0, 4, 1);
    look(6);
    check("R6 unflagged source ignored", {31'd0, rdNatA}, 0);
    check("R6 data", rdDataA, 32'h67);
    wr(2, 12, 32'hD, 0, 4, 1, 0, 0);
    look(12);
    check("R6 clean load clears", {31'd0, rdNatA}, 0);
  endtask

  task automatic t_priority();
    idle();
    wrLoad = 1; wrAluOp = 1; wrLoadFault = 1; wrAddr = 4'd13; wrData = 32'hD0;
    commit();
    look(13);
    check("R11 fault ignored on normal load", {31'd0, rdNatA}, 0);
    idle();
    wrLoad = 1; wrSpecLoad = 1; wrLoadFault = 1; wrAddr = 4'd13; wrData = 32'hD1;
    commit();
    look(13);
    check("R11 spec wins over load", {31'd0, rdNatA}, 1);
  endtask

  task automatic t_noFlags();
    idle();
    wrAddr = 4'd4; wrData = 32'hBAD; wrLoadFault = 1; wrSrcUseA = 1; rdAddrA = 4'd3;
    commit();
    look(4);
    check("R12 data unchanged", rdDataA, 32'h44);
    check("R12 poison unchanged", {31'd0, rdNatA}, 0);
  endtask

  task automatic t_bypass();
    idle();
    wrSpecLoad = 1; wrLoadFault = 1; wrAddr = 4'd8; wrData = 32'h88;
    rdAddrA = 4'd8; rdAddrB = 4'd8; chkAddr = 4'd8; chkEn = 1;
    #1;
    check("R9 bypass data", rdDataA, 32'h88);
    check("R9 bypass poison", {31'd0, rdNatB}, 1);
    check("R8 same-cycle fixup", {31'd0, chkFixup}, 1);
    commit();
    wr(1, 8, 32'h89, 0, 0, 0, 0, 0);
    idle();
    wrAluOp = 1; wrAddr = 4'd15; wrData = 32'hF00D; chkAddr = 4'd8; chkEn = 1; rdAddrA = 4'd15;
    #1;
    check("R9 bypass top register", rdDataA, 32'hF00D);
    check("R8 unrelated check clean", {31'd0, chkFixup}, 0);
    commit();
    look(15);
    check("R9 top register stored", rdDataA, 32'hF00D);
  endtask

  task automatic t_chain();
    wr(3, 9, 32'h9, 1, 0, 0, 0, 0);
    wr(1, 10, 32'hA, 0, 9, 1, 0, 0);
    wr(1, 11, 32'hB, 0, 4, 1, 10, 1);
    look(11);
    check("R10 single check at chain end", {31'd0, chkFixup}, 1);
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_zero();
    t_specFault();
    t_specOk();
    t_propagate();
    t_priority();
    t_noFlags();
    t_bypass();
    t_chain();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule